// File: doc/BRIEF.md
# Opcode-Selected 16-Bit Barrel Shifter

This block shifts or rotates a 16-bit word by 0 to 15 places in a single clock. A 3-bit opcode chooses the operation and the source of the shift distance. There are four operations: logical right shift, logical left shift, right rotate and left rotate. The distance comes from one of three 4-bit distance registers.

The main distance register serves all four operations. The two alternate registers serve only logical shifts, so rotates always use the main distance. Each register is written on its own load strobe. The shifted word leaves through one output register, so the result is available one clock after the operands are presented.

The datapath is a chain of four log-stages that move the word by 1, 2, 4 and 8 places. Each stage is enabled by one bit of the selected distance.

Top module: `bshift16`

## Requirements
- R1: Opcode 0 (3'b000) shifts the input right logically by the main distance: the low bits are dropped and the vacated upper bits become zero.
- R2: Opcode 1 (3'b001) shifts the input left logically by the main distance: the high bits are dropped and the vacated lower bits become zero.
- R3: Opcode 2 (3'b010) rotates right by the main distance, so bits leaving bit 0 re-enter at bit 15. Opcode 3 (3'b011) rotates left by the main distance, so bits leaving bit 15 re-enter at bit 0. A rotate keeps the number of one bits.
- R4: Opcodes 4 and 5 (3'b100, 3'b101) shift logically right and left by the alternate-A distance. Opcodes 6 and 7 (3'b110, 3'b111) shift logically right and left by the alternate-B distance.
- R5: Every distance is a 4-bit unsigned value from 0 to 15. A distance of 0 passes the input through unchanged for every opcode.
- R6: Each distance register takes its 4-bit load value at a rising clock edge where its own strobe is high. A strobe changes only its own register.
- R7: `dout` is registered. It shows the result for the `din` and `op` present at the preceding rising edge, using the distance register contents held before that edge. A distance loaded at an edge therefore first affects the result captured at the next edge.
- R8: While `rst_n` is low, `dout` and all three distance registers are zero, so after reset every opcode passes its input through.
- R9: A logical shift never produces more one bits than its input had, and a logical right shift never produces a larger unsigned value than its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 16 | Word to shift or rotate |
| op | input | 3 | Opcode: bit 0 selects left, bits 2:1 select the operation and distance source |
| main_ld | input | 1 | Load strobe for the main distance register |
| main_val | input | 4 | Value for the main distance register |
| alta_ld | input | 1 | Load strobe for the alternate-A distance register |
| alta_val | input | 4 | Value for the alternate-A distance register |
| altb_ld | input | 1 | Load strobe for the alternate-B distance register |
| altb_val | input | 4 | Value for the alternate-B distance register |
| dout | output | 16 | Registered result |

## Verification
On every cycle the assertions check three properties that do not depend on the distance:
- a rotate keeps the count of one bits;
- a logical shift never adds one bits, and a right shift never raises the unsigned value;
- a zero input gives a zero result.

Only the bench scenarios can show the exact bit positions and fill values for each opcode and distance. The same holds for the mapping of opcodes to distance registers, and for the rule that a load seen in the same cycle does not affect the result. The bench compares all eight opcodes at all sixteen distances on the patterns 0x8001, 0xFFFF and random words. It gives the three registers distinct values to expose a wrong distance source.

// File: rtl/bshift16.sv
module bshift16 #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         din,
  input  logic [2:0]           op,
  input  logic                 main_ld,
  input  logic [$clog2(W)-1:0] main_val,
  input  logic                 alta_ld,
  input  logic [$clog2(W)-1:0] alta_val,
  input  logic                 altb_ld,
  input  logic [$clog2(W)-1:0] altb_val,
  output logic [W-1:0]         dout
);
  localparam int AW = $clog2(W);

  logic [AW-1:0] main_q, alta_q, altb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      alta_q <= '0;
      altb_q <= '0;
    end else begin
      if (main_ld) main_q <= main_val;
      if (alta_ld) alta_q <= alta_val;
      if (altb_ld) altb_q <= altb_val;
    end
  end

  logic [AW-1:0] amt;
  logic          to_left, wrap;
  assign amt     = op[2] ? (op[1] ? altb_q : alta_q) : main_q;
  assign to_left = op[0];
  assign wrap    = (op[2:1] == 2'b01);

  logic [AW:0][W-1:0] stg;
  assign stg[0] = din;

  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic [W-1:0] lv, rv;
    assign lv = {stg[i][W-1-STEP:0], wrap ? stg[i][W-1:W-STEP] : {STEP{1'b0}}};
    assign rv = {wrap ? stg[i][STEP-1:0] : {STEP{1'b0}}, stg[i][W-1:STEP]};
    assign stg[i+1] = amt[i] ? (to_left ? lv : rv) : stg[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= stg[AW];
  end
endmodule

// File: rtl/bshift16_chk.sv
module bshift16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic [2:0]   op,
  input logic [W-1:0] dout
);
  always @(negedge clk) begin
    if (rst_n === 1'b0)
      assert_reset_clear_R8: assert (dout == '0);
  end

  assert_rotate_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op[2:1] == 2'b01) |=> ($countones(dout) == $countones($past(din))));

  assert_shift_no_new_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op[2:1] != 2'b01) |=> ($countones(dout) <= $countones($past(din))));

  assert_right_not_larger_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op[0] == 1'b0 && op[2:1] != 2'b01) |=> (dout <= $past(din)));

  assert_zero_in_zero_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (din == '0) |=> (dout == '0));
endmodule

bind bshift16 bshift16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .op(op), .dout(dout)
);

// File: tb/bshift16_test.sv
module bshift16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = '0;
  logic [2:0]  op = '0;
  logic        main_ld = 1'b0, alta_ld = 1'b0, altb_ld = 1'b0;
  logic [3:0]  main_val = '0, alta_val = '0, altb_val = '0;
  logic [15:0] dout;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_main = '0, m_alta = '0, m_altb = '0;

  always #10 clk = ~clk;

  bshift16 uut (
    .clk(clk), .rst_n(rst_n), .din(din), .op(op),
    .main_ld(main_ld), .main_val(main_val),
    .alta_ld(alta_ld), .alta_val(alta_val),
    .altb_ld(altb_ld), .altb_val(altb_val),
    .dout(dout)
  );

  function automatic logic [15:0] model(input logic [15:0] x, input logic [2:0] o,
                                        input logic [3:0] d);
    logic [15:0] y = '0;
    for (int i = 0; i < 16; i++) begin
      int src;
      if (o[0]) src = i - int'(d); else src = i + int'(d);
      if (o[2:1] == 2'b01) y[i] = x[(src + 16) % 16];
      else if (src >= 0 && src < 16) y[i] = x[src];
      else y[i] = 1'b0;
    end
    return y;
  endfunction

  function automatic logic [3:0] pick(input logic [2:0] o);
    if (!o[2]) return m_main;
    return o[1] ? m_altb : m_alta;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [2:0] o,
                       input logic lm, input logic [3:0] vm,
                       input logic la, input logic [3:0] va,
                       input logic lb, input logic [3:0] vb, input string tag);
    logic [15:0] exp;
    exp = model(x, o, pick(o));
    din = x; op = o;
    main_ld = lm; main_val = vm; alta_ld = la; alta_val = va; altb_ld = lb; altb_val = vb;
    if (lm) m_main = vm;
    if (la) m_alta = va;
    if (lb) m_altb = vb;
    @(negedge clk);
    main_ld = 0; alta_ld = 0; altb_ld = 0;
    check(dout, exp, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: dout=%h expected=done", dout);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pats [3];
    void'($urandom(32'h5EED));
    din = 16'hBEEF; op = 3'd3;
    repeat (2) @(negedge clk);
    check(dout, 16'h0000, "R8 reset output");
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      apply(16'hA5C3, 3'(o), 0, 0, 0, 0, 0, 0, "R8 distances zero after reset");

    // R1 R2 R3 R4 R5: every opcode at every distance
    pats[0] = 16'h8001; pats[1] = 16'hFFFF;
    for (int d = 0; d < 16; d++) begin
      apply(16'h0000, 3'd0, 1, 4'(d), 1, 4'(d), 1, 4'(d), "R6 load all");
      for (int o = 0; o < 8; o++) begin
        pats[2] = 16'($urandom);
        for (int p = 0; p < 3; p++)
          apply(pats[p], 3'(o), 0, 0, 0, 0, 0, 0,
                o < 2 ? (o == 0 ? "R1 right" : "R2 left") :
                o < 4 ? "R3 rotate" : "R4 alternate distance");
      end
    end

    // R4: distinct registers expose wrong source
    apply(16'h0000, 3'd0, 1, 4'd3, 1, 4'd5, 1, 4'd9, "R6 distinct load");
    for (int o = 0; o < 8; o++)
      apply(16'hF00D, 3'(o), 0, 0, 0, 0, 0, 0, "R4 source select");
    // R6: one strobe touches only its register
    apply(16'h1234, 3'd4, 0, 0, 1, 4'd1, 0, 0, "R6 alt-A load");
    apply(16'h1234, 3'd0, 0, 0, 0, 0, 0, 0, "R6 main kept");
    apply(16'h1234, 3'd6, 0, 0, 0, 0, 0, 0, "R6 alt-B kept");
    apply(16'h1234, 3'd4, 0, 0, 0, 0, 0, 0, "R6 alt-A new");
    // R7: same-cycle load uses old distance
    apply(16'h8000, 3'd0, 1, 4'd7, 0, 0, 0, 0, "R7 old distance in load cycle");
    apply(16'h8000, 3'd0, 0, 0, 0, 0, 0, 0, "R7 new distance next cycle");
    // R5 distance 15 extremes
    apply(16'h0000, 3'd0, 1, 4'd15, 0, 0, 0, 0, "R5 load 15");
    apply(16'h8000, 3'd0, 0, 0, 0, 0, 0, 0, "R5 right 15");
    apply(16'h0001, 3'd1, 0, 0, 0, 0, 0, 0, "R5 left 15");
    apply(16'h0001, 3'd2, 0, 0, 0, 0, 0, 0, "R3 rotate right 15");

    // random mix with random loads
    for (int n = 0; n < 600; n++)
      apply(16'($urandom), 3'($urandom), 1'($urandom), 4'($urandom),
            1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), "R7 random mix");

    // R8: reset mid-run clears output and distances
    apply(16'h0000, 3'd0, 1, 4'd6, 1, 4'd6, 1, 4'd6, "R6 preload");
    @(negedge clk) rst_n = 1'b0;
    #1 check(dout, 16'h0000, "R8 async reset output");
    @(negedge clk) rst_n = 1'b1;
    m_main = 0; m_alta = 0; m_altb = 0;
    for (int o = 0; o < 8; o++)
      apply(16'h9C31, 3'(o), 0, 0, 0, 0, 0, 0, "R8 distances cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule